// File: doc/BRIEF.md
# Per-Lane Write Alignment Pattern Checker

This block confirms, one byte lane after another, that a known write burst comes back from memory in the right clock cycle. Write calibration runs it. A start pulse clears the lane counter to zero and opens detection. Each read word captured for the current lane is compared against a fixed 64-bit alignment pattern. A correct word moves the checker on to the next lane. When the last lane matches, the checker reports done.

If the captured word is the pattern displaced by one or two clock cycles of data, the checker raises an early-by-one or early-by-two flag. Two bytes of data are assumed per clock. The flag stays up so that the write-leveling logic can move the memory clock. When that logic acknowledges the shift, detection restarts on the same lane. A 5-bit wait counter limits how long a lane may go without a recognised word. When it runs out, the checker reports an error and stops.

Top module: `wcal_checker`

## Requirements
- R1: After reset, laneCnt is 0 and patMatch, patMatchValid, early1, early2, done and err are all 0.
- R2: A start pulse sets laneCnt to 0 and clears done, err, early1 and early2. Detection begins with the wait count at zero.
- R3: During detection, rdValid with rdWord equal to 64'hFF00AA5555AA9966 on a lane other than the last raises laneCnt by one in the following cycle. In that same cycle, patMatch and patMatchValid are both 1 for exactly one cycle.
- R4: During detection, any rdValid word gives a one-cycle patMatchValid pulse. patMatch is 1 in that pulse only for an exact match. A word that is neither exact nor early leaves laneCnt unchanged.
- R5: An exact match on lane LANES-1 (7 by default) asserts done in the following cycle. laneCnt stays at LANES-1 and done stays high until the next start, and further read words are ignored: no patMatchValid and no laneCnt change.
- R6: During detection, a word that is not an exact match but has rdWord[63:16] equal to pattern bits [47:0] sets early1. early1 stays high until shiftAck, and laneCnt does not change.
- R7: During detection, a word that is neither exact nor early-by-one but has rdWord[63:32] equal to pattern bits [31:0] sets early2. early2 stays high until shiftAck, and laneCnt does not change.
- R8: shiftAck while an early flag is high clears the flag one cycle later. Detection then restarts on the same lane with the wait count at zero.
- R9: In detection, every cycle without a recognised word adds one to the wait count. The count is cleared by start, by a lane advance and by a restart after a shift. The 31st such cycle asserts err, which stays high until start. After err, laneCnt is frozen and words are ignored.
- R10: A match arriving in the 31st wait cycle takes priority over the timeout: err stays 0 and the lane advances.
- R11: While an early flag waits for shiftAck, no wait cycles are counted and read words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin calibration from lane 0 |
| rdValid | input | 1 | Captured read word is valid |
| rdWord | input | 64 | Captured read word for the current lane |
| shiftAck | input | 1 | Clock shift requested by an early flag has been made |
| laneCnt | output | 3 | Lane being checked (LANE_W bits) |
| patMatch | output | 1 | Last compared word was an exact match |
| patMatchValid | output | 1 | Qualifies patMatch |
| early1 | output | 1 | Data arrived one clock early |
| early2 | output | 1 | Data arrived two clocks early |
| done | output | 1 | All lanes matched |
| err | output | 1 | Wait count expired |

## Verification
A lane can exhaust its wait count in the same cycle that its pattern finally arrives. The bench provokes this by holding rdValid low for exactly 30 cycles after a lane opens and then presenting the exact pattern in the 31st cycle. The result is correct if err stays low and laneCnt advances. A second lane starved for 31 idle cycles must then raise err, which shows that the advance cleared the count. The last-lane match also coincides with done rising, and is judged by laneCnt holding at 7 while done goes high.

// File: rtl/wcal_pkg.sv
package wcal_pkg;
  localparam logic [63:0] ALIGN_PATTERN = 64'hFF00_AA55_55AA_9966;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DETECT, ST_SHIFT, ST_DONE, ST_FAIL
  } calState_t;

  typedef struct packed {
    logic clrLane;
    logic incLane;
    logic clrWait;
    logic incWait;
  } dpCtrl_t;
endpackage

// File: rtl/wcal_datapath.sv
module wcal_datapath
  import wcal_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int LANE_W    = 3,
  parameter int WAIT_W    = 5,
  parameter int STEP_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctrl,
  input  logic [63:0]       rdWord,
  output logic [2:0]        hitVec,
  output logic [LANE_W-1:0] laneCnt,
  output logic              lastLane,
  output logic              waitLast
);
  localparam logic [WAIT_W-1:0] WAIT_LIMIT = {WAIT_W{1'b1}} - 1'b1;
  localparam logic [LANE_W-1:0] LAST_LANE  = LANE_W'(LANES - 1);

  logic [WAIT_W-1:0] waitCnt;

  // hitVec[k]: word matches the pattern displaced by k cycles of data
  for (genvar k = 0; k < 3; k++) begin : g_cmp
    localparam int SH = k * STEP_BITS;
    assign hitVec[k] = (rdWord[63:SH] == ALIGN_PATTERN[63-SH:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      laneCnt <= '0;
      waitCnt <= '0;
    end else begin
      if (ctrl.clrLane)      laneCnt <= '0;
      else if (ctrl.incLane) laneCnt <= laneCnt + 1'b1;
      if (ctrl.clrWait)      waitCnt <= '0;
      else if (ctrl.incWait) waitCnt <= waitCnt + 1'b1;
    end
  end

  assign lastLane = (laneCnt == LAST_LANE);
  assign waitLast = (waitCnt == WAIT_LIMIT);

  // R3
  lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.incLane |-> !lastLane);
endmodule

// File: rtl/wcal_control.sv
module wcal_control
  import wcal_pkg::*;
#(
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rdValid,
  input  logic              shiftAck,
  input  logic [2:0]        hitVec,
  input  logic              lastLane,
  input  logic              waitLast,
  input  logic [LANE_W-1:0] laneCnt,
  output dpCtrl_t           ctrl,
  output logic              patMatch,
  output logic              patMatchValid,
  output logic              early1,
  output logic              early2,
  output logic              done,
  output logic              err
);
  calState_t state, nextState;
  logic hitExact, hitEarly1, hitEarly2, inDetect, shiftTaken;

  assign inDetect   = (state == ST_DETECT);
  assign hitExact   = rdValid & hitVec[0];
  assign hitEarly1  = rdValid & ~hitVec[0] & hitVec[1];
  assign hitEarly2  = rdValid & ~hitVec[0] & ~hitVec[1] & hitVec[2];
  assign shiftTaken = (state == ST_SHIFT) & shiftAck;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    if (start) begin
      ctrl.clrLane = 1'b1;
      ctrl.clrWait = 1'b1;
      nextState    = ST_DETECT;
    end else begin
      case (state)
        ST_DETECT: begin
          if (hitExact) begin
            if (lastLane) nextState = ST_DONE;
            else begin
              ctrl.incLane = 1'b1;
              ctrl.clrWait = 1'b1;
            end
          end else if (hitEarly1 || hitEarly2) begin
            nextState = ST_SHIFT;
          end else if (waitLast) begin
            nextState = ST_FAIL;
          end else begin
            ctrl.incWait = 1'b1;
          end
        end
        ST_SHIFT: begin
          if (shiftAck) begin
            ctrl.clrWait = 1'b1;
            nextState    = ST_DETECT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      patMatch      <= 1'b0;
      patMatchValid <= 1'b0;
      early1        <= 1'b0;
      early2        <= 1'b0;
    end else begin
      state         <= nextState;
      patMatchValid <= !start && inDetect && rdValid;
      patMatch      <= !start && inDetect && hitExact;
      if (start || shiftTaken) begin
        early1 <= 1'b0;
        early2 <= 1'b0;
      end else if (inDetect) begin
        if (hitEarly1) early1 <= 1'b1;
        if (hitEarly2) early2 <= 1'b1;
      end
    end
  end

  assign done = (state == ST_DONE);
  assign err  = (state == ST_FAIL);

  // R3
  match_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    patMatch |-> patMatchValid);

  // R6
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({early1, early2, done, err}));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(laneCnt)));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !start) |=> (err && $stable(laneCnt)));

  // R11
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((early1 || early2) && !shiftAck && !start) |=> ((early1 || early2) && $stable(laneCnt)));
endmodule

// File: rtl/wcal_checker.sv
module wcal_checker
  import wcal_pkg::*;
#(
  parameter int LANES     = 8,
  parameter int WAIT_W    = 5,
  parameter int STEP_BITS = 16,
  parameter int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rdValid,
  input  logic [63:0]       rdWord,
  input  logic              shiftAck,
  output logic [LANE_W-1:0] laneCnt,
  output logic              patMatch,
  output logic              patMatchValid,
  output logic              early1,
  output logic              early2,
  output logic              done,
  output logic              err
);
  dpCtrl_t    ctrl;
  logic [2:0] hitVec;
  logic       lastLane, waitLast;

  wcal_datapath #(
    .LANES(LANES), .LANE_W(LANE_W), .WAIT_W(WAIT_W), .STEP_BITS(STEP_BITS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .rdWord(rdWord),
    .hitVec(hitVec), .laneCnt(laneCnt), .lastLane(lastLane), .waitLast(waitLast)
  );

  wcal_control #(.LANE_W(LANE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .rdValid(rdValid),
    .shiftAck(shiftAck), .hitVec(hitVec), .lastLane(lastLane),
    .waitLast(waitLast), .laneCnt(laneCnt), .ctrl(ctrl),
    .patMatch(patMatch), .patMatchValid(patMatchValid),
    .early1(early1), .early2(early2), .done(done), .err(err)
  );
endmodule

// File: tb/wcal_checker_tb.sv
module wcal_checker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] PAT = 64'hFF00_AA55_55AA_9966;
  localparam logic [63:0] W_E1 = {PAT[47:0], 16'h1234};
  localparam logic [63:0] W_E2 = {PAT[31:0], 32'h0BAD_F00D};
  localparam logic [63:0] W_BAD = 64'h0123_4567_89AB_CDEF;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rdValid = 1'b0, shiftAck = 1'b0;
  logic [63:0] rdWord = '0;
  logic [2:0] laneCnt;
  logic patMatch, patMatchValid, early1, early2, done, err;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wcal_checker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rdValid(rdValid), .rdWord(rdWord),
    .shiftAck(shiftAck), .laneCnt(laneCnt), .patMatch(patMatch),
    .patMatchValid(patMatchValid), .early1(early1), .early2(early2),
    .done(done), .err(err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic feed(input logic v, input logic [63:0] w);
    rdValid = v; rdWord = w;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) feed(1'b0, '0);
  endtask

  task automatic pulseStart();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulseAck();
    shiftAck = 1'b1; @(negedge clk); shiftAck = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 laneCnt", laneCnt, 0);
    chk("R1 flags", {patMatch, patMatchValid, early1, early2, done, err}, 0);
  endtask

  task automatic testFullRun();
    pulseStart();
    chk("R2 laneCnt after start", laneCnt, 0);
    feed(1'b1, W_BAD);
    chk("R4 mismatch valid/match", {patMatchValid, patMatch}, 2'b10);
    chk("R4 mismatch lane", laneCnt, 0);
    for (int l = 0; l < 7; l++) begin
      feed(1'b1, PAT);
      chk("R3 lane step", laneCnt, l + 1);
      chk("R3 match pulse", {patMatchValid, patMatch}, 2'b11);
      idle(1);
      chk("R3 pulse ends", {patMatchValid, patMatch}, 2'b00);
    end
    chk("R5 not done before last", done, 0);
    feed(1'b1, PAT);
    chk("R5 done", done, 1);
    chk("R5 lane holds", laneCnt, 7);
    feed(1'b1, PAT);
    chk("R5 ignored valid", patMatchValid, 0);
    chk("R5 still done lane", {done, laneCnt}, {1'b1, 3'd7});
  endtask

  task automatic testEarly1();
    pulseStart();
    chk("R2 done cleared", done, 0);
    feed(1'b1, PAT);
    feed(1'b1, W_E1);
    chk("R6 early1", {early1, early2}, 2'b10);
    chk("R6 lane unchanged", laneCnt, 1);
    chk("R4 early no match", {patMatchValid, patMatch}, 2'b10);
    for (int i = 0; i < 40; i++) feed(1'b1, PAT);
    chk("R11 still waiting", {early1, err}, 2'b10);
    chk("R11 lane frozen", laneCnt, 1);
    pulseAck();
    chk("R8 flag cleared", early1, 0);
    idle(30);
    chk("R8 wait cleared", err, 0);
    feed(1'b1, PAT);
    chk("R8 same lane resumes", laneCnt, 2);
  endtask

  task automatic testEarly2();
    pulseStart();
    feed(1'b1, W_E2);
    chk("R7 early2", {early1, early2}, 2'b01);
    chk("R7 lane unchanged", laneCnt, 0);
    pulseAck();
    chk("R8 early2 cleared", early2, 0);
    feed(1'b1, PAT);
    chk("R8 lane after restart", laneCnt, 1);
  endtask

  task automatic testTimeout();
    pulseStart();
    idle(30);
    chk("R9 no err at 30", err, 0);
    feed(1'b1, PAT);
    chk("R10 match beats timeout", {err, laneCnt}, {1'b0, 3'd1});
    idle(30);
    chk("R9 no err at 30 on lane1", err, 0);
    idle(1);
    chk("R9 err at 31", err, 1);
    feed(1'b1, PAT);
    chk("R9 err freezes lane", {err, laneCnt, patMatchValid}, {1'b1, 3'd1, 1'b0});
    pulseStart();
    chk("R2 err cleared", {err, laneCnt}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testFullRun();
    testEarly1();
    testEarly2();
    testTimeout();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule